// File: doc/BRIEF.md
# Adaptive Spectral Predictor with Bounded-Error Quantizer

This block is the prediction stage of a hyperspectral image compressor. Samples enter one per cycle in band-interleaved-by-pixel order, so all spectral bands of one spatial pixel arrive back to back. Each sample comes with a valid/ready handshake, a flag marking the first band of a pixel, a flag marking the last band, and a start-of-frame flag. The block predicts every sample from the reconstructed values of up to three earlier bands of the same pixel. It weights those values with a set of signed fixed-point coefficients kept separately for each band index.

The difference between the sample and its prediction is quantized with a step of 2·delta+1. As a result, the value a decoder rebuilds never differs from the original by more than delta; delta = 0 gives exact lossless coding. The quantized index is folded into an unsigned code for a downstream entropy coder. The reconstructed value, not the original, is kept as history for the following bands. It also drives a sign-based weight update, so a decoder that sees only the codes can follow the encoder exactly. All arithmetic is integer. Throughput is one sample per cycle, and the output follows its input by one register.

Top module: `spectral_pred`

## Requirements
- R1: `s_ready` is high exactly when the output register is empty or `m_ready` is high. An accepted sample shows up on `m_valid`/`m_code` in the next cycle. While `m_valid` is high and `m_ready` is low, `m_code` and `m_last` hold their values.
- R2: A sample with `s_first` high has band index 0. Each later sample of the pixel has the previous index plus one. `m_last` repeats the `s_last` of the sample that produced the code.
- R3: The prediction for band index 0 is the mid-scale value 32768.
- R4: For band index b ≥ 1, the prediction is floor((Σ w_j·h_j + 4096) / 8192), clipped to 0..65535. The sum runs over j < min(b,3). h_0, h_1 and h_2 are the reconstructed values of bands b-1, b-2 and b-3 of the same pixel, and w_j are band b's signed 16-bit weights with 13 fraction bits.
- R5: With e = sample − prediction and m = 2·delta+1, the quantized index is q = sign(e)·floor((|e|+delta)/m).
- R6: The reconstruction is prediction + q·m, clipped to 0..65535. It differs from the input sample by at most delta, and equals it when delta = 0.
- R7: The output code is 2q for q ≥ 0 and −2q−1 for q < 0, which gives the order 0, −1, 1, −2, 2, …
- R8: After each accepted sample of band b ≥ 1, each used weight w_j becomes w_j + s·(h_j >> 4), saturated to −32768..32767. Here s is the sign of (reconstruction − prediction).
- R9: A sample accepted with `s_sof` high sees every weight at its initial value: w_0 = 8192 (1.0) and w_1 = w_2 = 0. The start of a frame therefore repeats exactly the codes an earlier frame with the same data produced.
- R10: Right after reset, `m_valid` is low, `s_ready` is high, and all weights hold their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delta | input | DW | Maximum reconstruction error in data numbers |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | W | Input sample |
| s_first | input | 1 | Sample is band 0 of its pixel |
| s_last | input | 1 | Sample is the last band of its pixel |
| s_sof | input | 1 | Sample starts a frame; weights restart |
| m_valid | output | 1 | Output code valid |
| m_ready | input | 1 | Downstream takes the code |
| m_code | output | W+1 | Interleaved unsigned quantizer index |
| m_last | output | 1 | Code belongs to the last band of its pixel |

## Verification
The hardest state to reach from the ports is a set of weights driven into saturation. The clip of the prediction and the reconstruction at both ends of the range is hard to reach for the same reason. Ordinary correlated data keeps the weights near 1.0 and the residuals small. The stimulus therefore mixes frames of smoothly sloped spectra with frames whose bands jump between 0 and full scale, over many pixels, so the sign-driven updates pile up in one direction. A repeat of one frame after a start-of-frame flag checks that the weights really restart. Random backpressure on `m_ready` and random input gaps run throughout.

// File: rtl/spectral_pred.sv
module spectral_pred #(
  parameter int W     = 16,
  parameter int NB    = 16,
  parameter int DW    = 4,
  parameter int WF    = 13,
  parameter int MU    = 4,
  parameter int INIT0 = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] delta,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [W-1:0]  s_data,
  input  logic          s_first,
  input  logic          s_last,
  input  logic          s_sof,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [W:0]    m_code,
  output logic          m_last
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int AW = 2 * W + 4;
  localparam int EW = W + 2;
  localparam int RW = W + DW + 4;
  localparam int TW = W + 2;
  localparam logic [W-1:0] MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic signed [AW-1:0] PMAX = AW'((64'd1 << W) - 1);
  localparam logic signed [AW-1:0] PRND = AW'(1) <<< (WF - 1);
  localparam logic signed [RW-1:0] RMAX = RW'((64'd1 << W) - 1);
  localparam logic signed [TW-1:0] WMAX = TW'((1 << (W - 1)) - 1);
  localparam logic signed [TW-1:0] WMIN = -TW'(1 << (W - 1));

  function automatic logic signed [W-1:0] init_w(input int j);
    return (j == 0) ? W'(INIT0) : '0;
  endfunction

  logic signed [W-1:0] wgt [NB][3];
  logic [W-1:0]        hist [3];
  logic [BW-1:0]       bcnt;

  logic [BW-1:0]       band;
  logic                take;
  logic signed [W-1:0] wc [3];
  logic signed [W-1:0] nw [3];
  logic [2:0]          use_n;
  logic signed [AW-1:0] acc, psh;
  logic [W-1:0]        pred, rec;
  logic signed [EW-1:0] e;
  logic                neg, qneg;
  logic [W:0]          mag, sumq, qmag;
  logic [DW:0]         m;
  logic [W+DW+1:0]     qm;
  logic signed [RW-1:0] rsum;
  logic [W:0]          code;
  logic                up, dn;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign band    = s_first ? '0 : bcnt;
  assign m       = {delta, 1'b1};

  always_comb begin
    acc = '0;
    for (int j = 0; j < 3; j++) begin
      wc[j]    = s_sof ? init_w(j) : wgt[band][j];
      use_n[j] = (32'(band) > j);
      if (use_n[j])
        acc = acc + AW'(wc[j]) * AW'($signed({1'b0, hist[j]}));
    end
    psh = (acc + PRND) >>> WF;
    if (band == '0)     pred = MID;
    else if (psh < 0)   pred = '0;
    else if (psh > PMAX) pred = MAXV;
    else                pred = psh[W-1:0];
  end

  assign e    = $signed({2'b00, s_data}) - $signed({2'b00, pred});
  assign neg  = e[EW-1];
  assign mag  = neg ? (W+1)'(-e) : (W+1)'(e);
  assign sumq = mag + (W+1)'(delta);
  assign qmag = sumq / (W+1)'(m);
  assign qneg = neg && (qmag != '0);
  assign qm   = (W+DW+2)'(qmag) * (W+DW+2)'(m);

  always_comb begin
    if (qneg) rsum = $signed(RW'(pred)) - $signed(RW'(qm));
    else      rsum = $signed(RW'(pred)) + $signed(RW'(qm));
    if (rsum < 0)         rec = '0;
    else if (rsum > RMAX) rec = MAXV;
    else                  rec = rsum[W-1:0];
  end

  assign code = qneg ? (W+1)'({qmag, 1'b0} - (W+2)'(1)) : (W+1)'({qmag, 1'b0});
  assign up   = rec > pred;
  assign dn   = rec < pred;

  always_comb begin
    for (int j = 0; j < 3; j++) begin
      logic signed [TW-1:0] t, st;
      st = $signed(TW'(hist[j] >> MU));
      t  = TW'(wc[j]);
      if (up)      t = t + st;
      else if (dn) t = t - st;
      if (!use_n[j])   nw[j] = wc[j];
      else if (t > WMAX) nw[j] = WMAX[W-1:0];
      else if (t < WMIN) nw[j] = WMIN[W-1:0];
      else             nw[j] = t[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_code  <= '0;
      m_last  <= 1'b0;
      bcnt    <= '0;
      for (int j = 0; j < 3; j++) hist[j] <= '0;
      for (int b = 0; b < NB; b++)
        for (int j = 0; j < 3; j++) wgt[b][j] <= init_w(j);
    end else begin
      if (s_ready) m_valid <= s_valid;
      if (take) begin
        m_code  <= code;
        m_last  <= s_last;
        hist[0] <= rec;
        hist[1] <= hist[0];
        hist[2] <= hist[1];
        if (s_last)                  bcnt <= '0;
        else if (band == BW'(NB - 1)) bcnt <= band;
        else                         bcnt <= band + 1'b1;
        if (s_sof)
          for (int b = 0; b < NB; b++)
            for (int j = 0; j < 3; j++) wgt[b][j] <= init_w(j);
        for (int j = 0; j < 3; j++) wgt[band][j] <= nw[j];
      end
    end
  end
endmodule

// File: rtl/spectral_pred_chk.sv
module spectral_pred_chk #(
  parameter int W  = 16,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] delta,
  input logic          s_valid,
  input logic          s_ready,
  input logic [W-1:0]  s_data,
  input logic          s_last,
  input logic          m_valid,
  input logic          m_ready,
  input logic [W:0]    m_code,
  input logic          m_last,
  input logic [W-1:0]  rec
);
  logic [W-1:0] diff;
  assign diff = (rec >= s_data) ? rec - s_data : s_data - rec;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_code) && $stable(m_last));

  assert_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  assert_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_last == $past(s_last));

  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |-> diff <= W'(delta));

  assert_lossless_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && delta == '0 |-> rec == s_data);
endmodule

bind spectral_pred spectral_pred_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .delta(delta), .s_valid(s_valid), .s_ready(s_ready),
  .s_data(s_data), .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
  .m_code(m_code), .m_last(m_last), .rec(rec)
);

// File: tb/spectral_pred_bench.sv
`timescale 1ns/1ps
module spectral_pred_bench;
  localparam int W = 16, NB = 16, DW = 4;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] delta = '0;
  logic s_valid = 0, s_first = 0, s_last = 0, s_sof = 0, m_ready = 0;
  logic [W-1:0] s_data = '0;
  logic s_ready, m_valid, m_last;
  logic [W:0] m_code;

  always #2 clk = ~clk;

  spectral_pred u_spectral_pred (
    .clk(clk), .rst_n(rst_n), .delta(delta), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .s_sof(s_sof),
    .m_valid(m_valid), .m_ready(m_ready), .m_code(m_code), .m_last(m_last));

  typedef struct {int code; int last; int pred; int s; int d; int band; int hx; bit adapted;} exp_t;
  exp_t qe[$];
  int outlog[$];
  int nchk = 0, nfail = 0;
  int mw [NB][3];
  int mh [3];
  bit mupd [NB];
  int mb = 0;
  bit took = 0, hold_pend = 0, lat_pend = 0, force_ready = 0, done = 0;
  int hold_code, hold_last, cur_hx = -1;
  int fbuf[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int clip16(input longint v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return int'(v);
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      mw[b][0] = 8192; mw[b][1] = 0; mw[b][2] = 0; mupd[b] = 0;
    end
  endtask

  task automatic model(input int s, input bit f, input bit l, input bit sof, input int d, output exp_t x);
    int b, pred, e, mag, m, qm, q, rec, sg;
    int wc [3];
    longint acc;
    b = f ? 0 : mb;
    if (sof) model_reset();
    for (int j = 0; j < 3; j++) wc[j] = mw[b][j];
    if (b == 0) pred = 32768;
    else begin
      acc = 0;
      for (int j = 0; j < 3; j++) if (j < b) acc += longint'(wc[j]) * mh[j];
      pred = clip16((acc + 4096) >>> 13);
    end
    e = s - pred; mag = (e < 0) ? -e : e; m = 2 * d + 1;
    qm = (mag + d) / m; q = (e < 0) ? -qm : qm;
    rec = clip16(longint'(pred) + q * m);
    x.code = (q < 0) ? -2 * q - 1 : 2 * q;
    x.adapted = mupd[b];
    sg = (rec > pred) ? 1 : (rec < pred) ? -1 : 0;
    for (int j = 0; j < 3; j++) if (j < b) mw[b][j] = sat16(wc[j] + sg * (mh[j] >> 4));
    if (b > 0) mupd[b] = 1;
    mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = rec;
    mb = l ? 0 : ((b == NB - 1) ? b : b + 1);
    x.last = l; x.pred = pred; x.s = s; x.d = d; x.band = b; x.hx = cur_hx;
  endtask

  always begin
    @(negedge clk);
    m_ready = force_ready || ($urandom_range(0, 3) != 0);
    #1;
    if (rst_n) begin
      if (hold_pend) begin
        chk(m_valid && m_code == hold_code && m_last == hold_last, "R1 stalled output held", int'(m_code), hold_code);
        hold_pend = 0;
      end
      if (lat_pend) begin
        chk(m_valid, "R1 one-cycle latency", int'(m_valid), 1);
        lat_pend = 0;
      end
      if (m_valid && m_ready) begin
        if (qe.size() == 0) chk(0, "R1 unexpected output", int'(m_code), -1);
        else begin
          exp_t x; int aq, arec, m;
          x = qe.pop_front();
          outlog.push_back(int'(m_code));
          chk(int'(m_code) == x.code,
              x.band == 0 ? "R3 R5 R7 code" : (x.adapted ? "R8 R5 R7 code" : "R4 R5 R7 code"),
              int'(m_code), x.code);
          chk(int'(m_last) == x.last, "R2 last flag", int'(m_last), x.last);
          if (x.hx >= 0) chk(int'(m_code) == x.hx, "R7 directed code", int'(m_code), x.hx);
          m = 2 * x.d + 1;
          aq = m_code[0] ? -((int'(m_code) + 1) / 2) : int'(m_code) / 2;
          arec = clip16(longint'(x.pred) + aq * m);
          chk((arec - x.s <= x.d) && (x.s - arec <= x.d), "R6 error bound", arec, x.s);
        end
      end else if (m_valid) begin
        hold_pend = 1; hold_code = int'(m_code); hold_last = int'(m_last);
      end
      if (s_valid && s_ready) begin
        exp_t x;
        model(int'(s_data), s_first, s_last, s_sof, int'(delta), x);
        qe.push_back(x);
        took = 1; lat_pend = 1;
      end
    end
  end

  task automatic send(input int s, input bit f, input bit l, input bit sof, input int d, input int hx);
    if ($urandom_range(0, 4) == 0) begin
      @(negedge clk); s_valid = 0;
    end
    @(negedge clk);
    s_valid = 1; s_data = W'(s); s_first = f; s_last = l; s_sof = sof; delta = DW'(d);
    cur_hx = hx; took = 0;
    forever begin
      @(posedge clk);
      if (took) break;
    end
  endtask

  task automatic idle();
    @(negedge clk); s_valid = 0;
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 400 && qe.size() != 0; i++) @(posedge clk);
    chk(qe.size() == 0, "R1 all outputs delivered", qe.size(), 0);
  endtask

  task automatic gen_frame(input int npix, input int nb, input int kind);
    int base, slope;
    fbuf.delete();
    slope = $urandom_range(0, 6000) - 3000;
    for (int p = 0; p < npix; p++) begin
      base = $urandom_range(2000, 60000);
      for (int b = 0; b < nb; b++) begin
        if (kind == 1) fbuf.push_back((((b + p) % 2) != 0) ? 65535 : 0);
        else fbuf.push_back(clip16(longint'(base + b * slope + $urandom_range(0, 100) - 50)));
      end
    end
  endtask

  task automatic play(input int npix, input int nb, input int d);
    for (int p = 0; p < npix; p++)
      for (int b = 0; b < nb; b++)
        send(fbuf[p * nb + b], b == 0, b == nb - 1, p == 0 && b == 0, d, -1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    for (int j = 0; j < 3; j++) mh[j] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!m_valid, "R10 reset m_valid low", int'(m_valid), 0);
    chk(s_ready, "R10 reset s_ready high", int'(s_ready), 1);
    @(negedge clk); rst_n = 1;

    // R3 R7 band-0 corners, delta 0
    send(32768, 1, 1, 1, 0, 0);
    send(0, 1, 1, 0, 0, 65535);
    send(65535, 1, 1, 0, 0, 65534);
    send(32778, 1, 1, 0, 0, 20);
    // R5 delta 3: e=10 -> q=1
    send(32778, 1, 1, 0, 3, 2);
    // R5 delta 3: e=-11 -> q=-2 -> code 3
    send(32757, 1, 1, 0, 3, 3);
    // R4 initial weights copy previous band: 1000 then 1000 -> code 0
    send(1000, 1, 0, 1, 0, -1);
    send(1000, 0, 1, 0, 0, 0);
    drain();

    for (int fr = 0; fr < 12; fr++) begin
      int nb = $urandom_range(1, 8);
      gen_frame(40, nb, (fr % 4 == 3) ? 1 : 0);
      play(40, nb, (fr % 3 == 0) ? 0 : $urandom_range(0, 15));
    end
    drain();

    // R8 saturation pressure: long extreme frame
    gen_frame(300, 4, 1);
    play(300, 4, 0);
    drain();

    // R9 frame restart repeats codes
    begin
      int a0, a1, b0;
      int keep[$];
      gen_frame(30, 5, 0);
      keep = fbuf;
      a0 = outlog.size(); play(30, 5, 2); drain(); a1 = outlog.size();
      gen_frame(30, 5, 1); play(30, 5, 2); drain();
      fbuf = keep;
      b0 = outlog.size(); play(30, 5, 2); drain();
      for (int i = 0; i < a1 - a0; i++)
        chk(outlog[b0 + i] == outlog[a0 + i], "R9 restart repeats code", outlog[b0 + i], outlog[a0 + i]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule